// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a small programmable logic array. It receives the OR-plane sum for its output, an output-enable product term, a shared synchronous preset term, a shared asynchronous clear term, a clock from a pin and a clock from a product term. It returns a drive value with a tri-state enable for the pad, and one feedback bit for the AND plane. A static mode word picks the output path, the polarity and the feedback source. A two-bit clock setting picks the clock source and its sense.

The storage element is a D flip-flop. It runs on the block's system clock. The chosen cell clock is sampled and used as a rising-edge enable. The asynchronous clear is applied to the flip-flop value without delay on its way to the output path and the feedback path. The stored bit is then also cleared at the next system edge. The mode word is decoded combinationally into twelve legal configurations. The one reserved encoding falls back to a plain combinational cell.

Top module: `pld_out_cell`

## Requirements
- R1: On a system-clock edge with `rst` high, the stored bit becomes 0 and the sampled cell-clock level is taken as high. After reset, nothing is captured until the selected clock has been seen low and then high.
- R2: A low-to-high change of the selected cell clock between two system edges loads `sum_term` into the stored bit. With no such change the stored bit holds.
- R3: When `preset_term` is high at a capturing cell-clock edge, the stored bit becomes 1 whatever `sum_term` is.
- R4: While `clear_term` is high, the register value seen by the output and feedback paths is 0 in the same cycle. The stored bit is 0 from the next system edge onward, and clock edges are ignored.
- R5: When `clear_term` and `preset_term` are both high at a capturing edge, the stored bit ends at 0.
- R6: `mode[1]`=1 drives the register value to the pin and `mode[1]`=0 drives `sum_term`. `mode[0]`=1 drives that value as is and `mode[0]`=0 drives it inverted.
- R7: `mode[3:2]` chooses the feedback: 00 gives `pin_in`, 01 gives the register value (true sense), and 10 gives `sum_term` (true sense). This choice does not depend on `mode[1]`.
- R8: `pin_oe` is high exactly when `oe_term` is high.
- R9: `clk_src`=0 selects `pin_clk` and `clk_src`=1 selects `pt_clk`. `clk_inv`=1 uses the complement of the selected clock, so a falling raw clock captures. The unselected clock has no effect.
- R10: The reserved mode `mode[3:2]`=11 behaves as a combinational, active-high output with pin feedback, whatever `mode[1:0]` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode | input | 4 | Static cell mode word |
| clk_src | input | 1 | Cell clock source: 0 pin clock, 1 product-term clock |
| clk_inv | input | 1 | Use the complement of the selected cell clock |
| sum_term | input | 1 | OR-plane sum for this cell |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Shared synchronous preset term |
| clear_term | input | 1 | Shared asynchronous clear term |
| pin_clk | input | 1 | Clock from the dedicated clock pin |
| pt_clk | input | 1 | Clock from a product term |
| pin_in | input | 1 | Level read back from the pad |
| pin_out | output | 1 | Value to drive on the pad |
| pin_oe | output | 1 | Pad driver enable; high-impedance when low |
| fb_out | output | 1 | Feedback bit to the AND plane |

## Verification
The hardest case to reach is a cycle where clear, preset and a real edge of the selected clock all line up. The register also has to be visible on the pin or the feedback at that moment, and for the inverted product-term clock the capturing edge is a falling raw edge. A directed opening sequence builds each of these cycles on purpose from a known stored value. It covers reset, the hold behaviour, clear together with preset on an edge, and the switch to the inverted product-term clock. After that, a sweep walks every mode word and every clock setting, driving pseudo-random terms and clocks cycle by cycle. A bench model of the flip-flop supplies the expected value of all three outputs on every cycle.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    localparam int MODE_W   = 4;
    localparam int FB_SEL_W = 2;

    typedef enum logic [FB_SEL_W-1:0] {
        FB_PIN = 2'b00,
        FB_REG = 2'b01,
        FB_SUM = 2'b10,
        FB_RSV = 2'b11
    } fb_sel_e;

    typedef struct packed {
        fb_sel_e fb_sel;
        logic    registered;
        logic    active_high;
    } cell_mode_t;

    typedef struct packed {
        logic src_pterm;
        logic invert;
    } clk_cfg_t;

    // Reserved feedback code selects the safe combinational, active-high, pin-feedback cell.
    function automatic cell_mode_t decode_mode(input logic [MODE_W-1:0] raw);
        cell_mode_t m;
        if (raw[MODE_W-1 -: FB_SEL_W] == FB_RSV) begin
            m.fb_sel      = FB_PIN;
            m.registered  = 1'b0;
            m.active_high = 1'b1;
        end else begin
            m.fb_sel      = fb_sel_e'(raw[MODE_W-1 -: FB_SEL_W]);
            m.registered  = raw[1];
            m.active_high = raw[0];
        end
        return m;
    endfunction

endpackage

// File: rtl/pld_clk_edge.sv
module pld_clk_edge
    import pld_cell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t ccfg,
    input  logic     pin_clk,
    input  logic     pt_clk,
    output logic     cap_edge
);
    logic sel_lvl;
    logic prev_lvl;

    assign sel_lvl  = (ccfg.src_pterm ? pt_clk : pin_clk) ^ ccfg.invert;
    assign cap_edge = sel_lvl & ~prev_lvl;

    // Held high in reset so a level already high afterwards is not taken as an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= sel_lvl;
    end

    // R1: no capture in the first cycle after reset
    p_no_edge_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cap_edge);

endmodule

// File: rtl/pld_cell_ff.sv
module pld_cell_ff (
    input  logic clk,
    input  logic rst,
    input  logic cap_edge,
    input  logic sum_term,
    input  logic preset_term,
    input  logic clear_term,
    output logic q_eff
);
    logic q_reg;

    always_ff @(posedge clk) begin
        if (rst)             q_reg <= 1'b0;
        else if (clear_term) q_reg <= 1'b0;
        else if (cap_edge)   q_reg <= preset_term | sum_term;
    end

    // Clear reaches the cell at once, ahead of the stored bit.
    assign q_eff = q_reg & ~clear_term;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> !q_reg);

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_edge && !preset_term && !clear_term) |=> (q_reg == $past(sum_term)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cap_edge && !clear_term) |=> $stable(q_reg));

    p_preset_high_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_edge && preset_term && !clear_term) |=> q_reg);

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        clear_term |=> !q_reg);

endmodule

// File: rtl/pld_cell_out.sv
module pld_cell_out
    import pld_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_mode_t mcfg,
    input  logic       sum_term,
    input  logic       q_eff,
    input  logic       clear_term,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       fb_out
);
    logic core_val;

    assign core_val = mcfg.registered ? q_eff : sum_term;
    assign pin_out  = mcfg.active_high ? core_val : ~core_val;

    always_comb begin
        unique case (mcfg.fb_sel)
            FB_REG:  fb_out = q_eff;
            FB_SUM:  fb_out = sum_term;
            default: fb_out = pin_in;
        endcase
    end

    // R4: a registered output shows the inactive level while clear holds
    p_clear_forces_low_r4: assert property (@(posedge clk) disable iff (rst)
        (clear_term && mcfg.registered) |-> (pin_out == !mcfg.active_high));

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
    import pld_cell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              clk_src,
    input  logic              clk_inv,
    input  logic              sum_term,
    input  logic              oe_term,
    input  logic              preset_term,
    input  logic              clear_term,
    input  logic              pin_clk,
    input  logic              pt_clk,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    cell_mode_t mcfg;
    clk_cfg_t   ccfg;
    logic       cap_edge;
    logic       q_eff;

    assign mcfg = decode_mode(mode);
    assign ccfg = '{src_pterm: clk_src, invert: clk_inv};

    pld_clk_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .ccfg     (ccfg),
        .pin_clk  (pin_clk),
        .pt_clk   (pt_clk),
        .cap_edge (cap_edge)
    );

    pld_cell_ff u_ff (
        .clk         (clk),
        .rst         (rst),
        .cap_edge    (cap_edge),
        .sum_term    (sum_term),
        .preset_term (preset_term),
        .clear_term  (clear_term),
        .q_eff       (q_eff)
    );

    pld_cell_out u_out (
        .clk        (clk),
        .rst        (rst),
        .mcfg       (mcfg),
        .sum_term   (sum_term),
        .q_eff      (q_eff),
        .clear_term (clear_term),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .fb_out     (fb_out)
    );

    assign pin_oe = oe_term;

endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, csrc, cinv, sum, oe, pre, clr, pclk, tclk, pin_in;
    logic [3:0] mode;
    logic       pin_out, pin_oe, fb;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic mq, mprev;
    logic [15:0] lfsr = 16'hACE1;

    pld_out_cell u_dut (
        .clk(clk), .rst(rst), .mode(mode), .clk_src(csrc), .clk_inv(cinv),
        .sum_term(sum), .oe_term(oe), .preset_term(pre), .clear_term(clr),
        .pin_clk(pclk), .pt_clk(tclk), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then advance the bench model across the rising edge.
    task automatic step(input string tag);
        logic rsv, ah, rg, qe, val, selc;
        logic [1:0] fs;
        string to, tf;
        @(negedge clk);
        rsv  = (mode[3:2] == 2'b11);
        ah   = rsv | mode[0];
        rg   = !rsv & mode[1];
        fs   = rsv ? 2'b00 : mode[3:2];
        qe   = mq & ~clr;
        val  = rg ? qe : sum;
        to   = (tag != "") ? tag : (rsv ? "R10" : "R6");
        tf   = (tag != "") ? tag : (rsv ? "R10" : "R7");
        chk(to, "pin_out", pin_out, ah ? val : ~val);
        chk(tf, "fb_out", fb, (fs == 2'b00) ? pin_in : ((fs == 2'b01) ? qe : sum));
        chk("R8", "pin_oe", pin_oe, oe);
        selc = (csrc ? tclk : pclk) ^ cinv;
        if (rst) begin
            mq = 1'b0; mprev = 1'b1;
        end else begin
            if (clr)                 mq = 1'b0;
            else if (selc && !mprev) mq = pre | sum;
            mprev = selc;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        mq = 1'b0; mprev = 1'b1;
        rst = 1'b1; mode = 4'b0111; csrc = 1'b0; cinv = 1'b0;
        sum = 1'b0; oe = 1'b1; pre = 1'b0; clr = 1'b0;
        pclk = 1'b0; tclk = 1'b0; pin_in = 1'b0;
        step("R1");
        // R1: level already high after reset is not an edge
        rst = 1'b0; pclk = 1'b1; sum = 1'b1; step("R1");
        step("R1");
        // R2: real edge captures, then holds while the clock stays high
        pclk = 1'b0; step("R2");
        pclk = 1'b1; step("R2");
        sum = 1'b0; step("R2");
        step("R2");
        pclk = 1'b0; step("R2");
        pclk = 1'b1; step("R2");
        step("R2");
        // R3: preset sets the bit with sum low
        pclk = 1'b0; pre = 1'b1; step("R3");
        pclk = 1'b1; step("R3");
        pre = 1'b0; step("R3");
        // R4: clear drops the visible bit at once and blocks edges
        clr = 1'b1; step("R4");
        pclk = 1'b0; sum = 1'b1; step("R4");
        pclk = 1'b1; step("R4");
        // R5: clear and preset together on an edge
        pclk = 1'b0; clr = 1'b0; step("R5");
        pclk = 1'b1; step("R5");
        pclk = 1'b0; step("R5");
        pclk = 1'b1; pre = 1'b1; clr = 1'b1; step("R5");
        pre = 1'b0; clr = 1'b0; step("R5");
        // R9: unselected clock ignored, then inverted product-term clock
        sum = 1'b1; pclk = 1'b1;
        tclk = 1'b1; step("R9");
        tclk = 1'b0; step("R9");
        tclk = 1'b1; step("R9");
        csrc = 1'b1; cinv = 1'b1; step("R9");
        tclk = 1'b0; step("R9");
        step("R9");
        sum = 1'b0; tclk = 1'b1; step("R9");
        tclk = 1'b0; step("R9");
        step("R9");
        // Sweep every mode word and clock setting (R6, R7, R8, R10 checked each cycle)
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 4; c++) begin
                mode = 4'(m); csrc = c[0]; cinv = c[1];
                rst = 1'b1; step("R1");
                rst = 1'b0;
                for (int k = 0; k < 48; k++) begin
                    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    pclk   = lfsr[0];
                    tclk   = lfsr[1];
                    pin_in = lfsr[2];
                    sum    = lfsr[3];
                    clr    = lfsr[5] & lfsr[4];
                    pre    = !(lfsr[7] | lfsr[6]);
                    oe     = lfsr[8];
                    step("");
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule